// File: doc/BRIEF.md
# Pessimistic Speculative Switch Allocator

This block builds one cycle's crossbar schedule for a virtual-channel router. Two request sets arrive as flat vectors with one bit for each pair of input port and output port. The first set holds non-speculative requests, from flits whose virtual channel is already held. The second holds speculative requests, from head flits that are still being handled by VC allocation in the same cycle. Each set feeds its own separable input-first allocator built from round-robin arbiters, and the two allocators run side by side.

Speculative grants are not filtered by the non-speculative grants. They are filtered by the non-speculative requests, on the pessimistic assumption that every non-speculative request will win. A speculative grant survives only when neither its input nor its output appears in any non-speculative request. This takes the non-speculative grant path out of the mask logic. The cost is an occasional lost crossbar slot at high load.

The final schedule is the OR of the non-speculative grants and the surviving speculative grants. The block marks each input whose grant is speculative. Together with a per-input VC-allocation result, it flags mis-speculated grants so that the crossbar slot can be thrown away. The grants are combinational in the request inputs. Arbiter pointers are the only state.

Top module: `switch_alloc_pess`

## Requirements
- R1: A bit of `grant` at (input i, output o), at flat index i*NUM_OUT+o, is set only when the non-speculative or the speculative request at that same index is set.
- R2: In `grant`, each input has at most one output set and each output has at most one input set.
- R3: With no speculative request pending, `grant` equals the result of a separable input-first round-robin allocation of `ns_req`. In that allocation each input arbiter first picks one requested output, and each output arbiter then picks one of the inputs that chose it.
- R4: A speculative grant to input i is dropped whenever `ns_req` has any bit set for input i, whether or not that request is granted.
- R5: A speculative grant to output o is dropped whenever `ns_req` has any bit set for output o, from any input.
- R6: A speculative allocation that is not dropped appears in `grant`, and `grant_spec[i]` is 1 exactly when input i holds such a surviving speculative grant.
- R7: `misspec[i]` is 1 exactly when `grant_spec[i]` is 1 and `vc_won[i]` is 0.
- R8: A speculative allocation that is dropped leaves the speculative arbiter pointers unchanged. Only final grants move a pointer.
- R9: After a final grant at (i, o), input i's arbiter in that class next favours output o+1, and output o's arbiter next favours input i+1, both modulo their counts.
- R10: While `rst_n` is low, all pointers are cleared. After reset, the lowest index has first priority in every arbiter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; pointers update on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ns_req | input | NUM_IN*NUM_OUT | Non-speculative requests, bit i*NUM_OUT+o |
| sp_req | input | NUM_IN*NUM_OUT | Speculative requests, same layout |
| vc_won | input | NUM_IN | Per input: its VC allocation succeeded this cycle |
| grant | output | NUM_IN*NUM_OUT | Final crossbar schedule, same layout |
| grant_spec | output | NUM_IN | Input holds a surviving speculative grant |
| misspec | output | NUM_IN | Speculative grant whose VC allocation failed |

## Verification
`grant`, `grant_spec` and `misspec` are due in the same cycle as the requests, because no register lies between them. The bench therefore drives its inputs on the falling edge and samples 2 ns later, well before the next rising edge. The effect of a grant on the arbiter pointers shows up one cycle later. The bench advances its own pointer model only after the rising edge that follows each sample, so every expected schedule is computed from the pointers that were in force when it was sampled.

// File: rtl/swalloc_pkg.sv
package swalloc_pkg;
    // flat position of the (input, output) pair in request and grant vectors
    function automatic int pair_idx(input int inp, input int outp, input int n_out);
        return inp * n_out + outp;
    endfunction
endpackage

// File: rtl/swa_rr_arb.sv
module swa_rr_arb #(
    parameter int N = 4,
    localparam int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         adv,
    output logic [N-1:0] gnt
);
    logic [PW-1:0] ptr;
    logic [PW-1:0] win;
    logic          found;

    always_comb begin
        gnt   = '0;
        win   = '0;
        found = 1'b0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(ptr) + k) % N;
            if (!found && req[idx]) begin
                gnt[idx] = 1'b1;
                win      = PW'(idx);
                found    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (adv && found)
            ptr <= PW'((int'(win) + 1) % N);
    end

    assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ptr));
    assert_arb_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    assert_arb_subset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);
endmodule

// File: rtl/swa_sep_alloc.sv
module swa_sep_alloc #(
    parameter int NI = 4,
    parameter int NO = 4,
    localparam int NP = NI * NO
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] req,
    input  logic [NP-1:0] keep,
    output logic [NP-1:0] gnt
);
    import swalloc_pkg::*;

    logic [NP-1:0]          stage1;
    logic [NO-1:0][NI-1:0]  col_req;
    logic [NO-1:0][NI-1:0]  col_gnt;
    logic [NO-1:0][NI-1:0]  col_keep;
    logic [NI-1:0]          in_adv;
    logic [NO-1:0]          out_adv;

    genvar gi, go;
    generate
        for (gi = 0; gi < NI; gi++) begin : g_in
            assign in_adv[gi] = |(gnt[gi*NO +: NO] & keep[gi*NO +: NO]);
            swa_rr_arb #(.N(NO)) u_in_arb (
                .clk (clk),
                .rst_n (rst_n),
                .req (req[gi*NO +: NO]),
                .adv (in_adv[gi]),
                .gnt (stage1[gi*NO +: NO])
            );
        end
        for (go = 0; go < NO; go++) begin : g_out
            for (gi = 0; gi < NI; gi++) begin : g_col
                assign col_req[go][gi]  = stage1[pair_idx(gi, go, NO)];
                assign col_keep[go][gi] = keep[pair_idx(gi, go, NO)];
                assign gnt[pair_idx(gi, go, NO)] = col_gnt[go][gi];
            end
            assign out_adv[go] = |(col_gnt[go] & col_keep[go]);
            swa_rr_arb #(.N(NI)) u_out_arb (
                .clk (clk),
                .rst_n (rst_n),
                .req (col_req[go]),
                .adv (out_adv[go]),
                .gnt (col_gnt[go])
            );
        end
    endgenerate
endmodule

// File: rtl/switch_alloc_pess.sv
module switch_alloc_pess #(
    parameter int NUM_IN  = 4,
    parameter int NUM_OUT = 4,
    localparam int NP = NUM_IN * NUM_OUT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NP-1:0]     ns_req,
    input  logic [NP-1:0]     sp_req,
    input  logic [NUM_IN-1:0] vc_won,
    output logic [NP-1:0]     grant,
    output logic [NUM_IN-1:0] grant_spec,
    output logic [NUM_IN-1:0] misspec
);
    import swalloc_pkg::*;

    logic [NP-1:0]      ns_gnt;
    logic [NP-1:0]      sp_gnt_raw;
    logic [NP-1:0]      sp_keep;
    logic [NP-1:0]      sp_gnt_fin;
    logic [NUM_IN-1:0]  ns_in_busy;
    logic [NUM_OUT-1:0] ns_out_busy;

    // conflict detection: driven by requests only, never by grants
    always_comb begin
        ns_out_busy = '0;
        for (int i = 0; i < NUM_IN; i++) begin
            ns_in_busy[i] = |ns_req[i*NUM_OUT +: NUM_OUT];
            for (int o = 0; o < NUM_OUT; o++)
                ns_out_busy[o] = ns_out_busy[o] | ns_req[pair_idx(i, o, NUM_OUT)];
        end
        for (int i = 0; i < NUM_IN; i++)
            for (int o = 0; o < NUM_OUT; o++)
                sp_keep[pair_idx(i, o, NUM_OUT)] = !ns_in_busy[i] && !ns_out_busy[o];
    end

    swa_sep_alloc #(.NI(NUM_IN), .NO(NUM_OUT)) u_ns_alloc (
        .clk (clk),
        .rst_n (rst_n),
        .req (ns_req),
        .keep ({NP{1'b1}}),
        .gnt (ns_gnt)
    );

    swa_sep_alloc #(.NI(NUM_IN), .NO(NUM_OUT)) u_sp_alloc (
        .clk (clk),
        .rst_n (rst_n),
        .req (sp_req),
        .keep (sp_keep),
        .gnt (sp_gnt_raw)
    );

    assign sp_gnt_fin = sp_gnt_raw & sp_keep;
    assign grant      = ns_gnt | sp_gnt_fin;

    genvar gi, go;
    generate
        for (gi = 0; gi < NUM_IN; gi++) begin : g_flag
            assign grant_spec[gi] = |sp_gnt_fin[gi*NUM_OUT +: NUM_OUT];
            assign misspec[gi]    = grant_spec[gi] & ~vc_won[gi];

            assert_spec_in_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
                grant_spec[gi] |-> (ns_req[gi*NUM_OUT +: NUM_OUT] == '0));
            assert_row_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(grant[gi*NUM_OUT +: NUM_OUT]));
            assert_misspec_spec_R7: assert property (@(posedge clk) disable iff (!rst_n)
                misspec[gi] |-> grant_spec[gi]);

            for (go = 0; go < NUM_OUT; go++) begin : g_pair
                assert_spec_out_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
                    (grant_spec[gi] && grant[pair_idx(gi, go, NUM_OUT)]) |-> !ns_out_busy[go]);
            end
        end
        for (go = 0; go < NUM_OUT; go++) begin : g_colchk
            logic [NUM_IN-1:0] col;
            for (gi = 0; gi < NUM_IN; gi++) begin : g_c
                assign col[gi] = grant[pair_idx(gi, go, NUM_OUT)];
            end
            assert_col_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(col));
        end
    endgenerate

    assert_grant_subset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~(ns_req | sp_req)) == '0);
endmodule

// File: tb/sim_switch_alloc_pess.sv
module sim_switch_alloc_pess;
    localparam int NI = 3;
    localparam int NO = 3;
    localparam int NP = NI * NO;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] ns_req = '0;
    logic [NP-1:0] sp_req = '0;
    logic [NI-1:0] vc_won = '0;
    logic [NP-1:0] grant;
    logic [NI-1:0] grant_spec;
    logic [NI-1:0] misspec;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    int ns_ip[NI];
    int ns_op[NO];
    int sp_ip[NI];
    int sp_op[NO];

    always #5 clk = ~clk;

    switch_alloc_pess #(.NUM_IN(NI), .NUM_OUT(NO)) u0 (
        .clk (clk), .rst_n (rst_n), .ns_req (ns_req), .sp_req (sp_req),
        .vc_won (vc_won), .grant (grant), .grant_spec (grant_spec), .misspec (misspec)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [NP-1:0] model(input logic [NP-1:0] req, input int ip[NI], input int op[NO]);
        logic [NP-1:0] s1 = '0;
        logic [NP-1:0] g = '0;
        for (int i = 0; i < NI; i++)
            for (int k = 0; k < NO; k++) begin
                int o = (ip[i] + k) % NO;
                if (req[i*NO+o]) begin s1[i*NO+o] = 1'b1; break; end
            end
        for (int o = 0; o < NO; o++)
            for (int k = 0; k < NI; k++) begin
                int i = (op[o] + k) % NI;
                if (s1[i*NO+o]) begin g[i*NO+o] = 1'b1; break; end
            end
        return g;
    endfunction

    function automatic logic [NP-1:0] keep_of(input logic [NP-1:0] ns);
        logic [NP-1:0] kp = '0;
        for (int i = 0; i < NI; i++)
            for (int o = 0; o < NO; o++) begin
                bit busy = 1'b0;
                for (int j = 0; j < NI; j++) busy |= ns[j*NO+o];
                for (int p = 0; p < NO; p++) busy |= ns[i*NO+p];
                kp[i*NO+o] = !busy;
            end
        return kp;
    endfunction

    task automatic step(input logic [NP-1:0] ns, input logic [NP-1:0] sp,
                        input logic [NI-1:0] vc, input string tag);
        logic [NP-1:0] eg_ns, eg_sp, eg;
        logic [NI-1:0] espec, emis;
        @(negedge clk);
        ns_req = ns; sp_req = sp; vc_won = vc;
        eg_ns = model(ns, ns_ip, ns_op);
        eg_sp = model(sp, sp_ip, sp_op) & keep_of(ns);
        eg    = eg_ns | eg_sp;
        for (int i = 0; i < NI; i++) begin
            espec[i] = |eg_sp[i*NO +: NO];
            emis[i]  = espec[i] & ~vc[i];
        end
        #2;
        chk({tag, " R1 R3 R4 R5 R9 grant"}, 32'(grant), 32'(eg));
        chk({tag, " R6 grant_spec"}, 32'(grant_spec), 32'(espec));
        chk({tag, " R7 misspec"}, 32'(misspec), 32'(emis));
        for (int i = 0; i < NI; i++)
            chk("R2 row", 32'($countones(grant[i*NO +: NO]) <= 1), 32'd1);
        for (int o = 0; o < NO; o++) begin
            int c = 0;
            for (int i = 0; i < NI; i++) c += int'(grant[i*NO+o]);
            chk("R2 col", 32'(c <= 1), 32'd1);
        end
        @(posedge clk);
        for (int i = 0; i < NI; i++)
            for (int o = 0; o < NO; o++) begin
                if (eg_ns[i*NO+o]) begin ns_ip[i] = (o + 1) % NO; ns_op[o] = (i + 1) % NI; end
                if (eg_sp[i*NO+o]) begin sp_ip[i] = (o + 1) % NO; sp_op[o] = (i + 1) % NI; end
            end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NI; i++) begin ns_ip[i] = 0; sp_ip[i] = 0; end
        for (int o = 0; o < NO; o++) begin ns_op[o] = 0; sp_op[o] = 0; end
        repeat (3) @(posedge clk);
        #1;
        chk("R10 grant in reset", 32'(grant), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: fresh pointers favour the lowest index
        step('1, '0, '1, "R10 all requests after reset");
        // R8: masked speculative grant must not move the speculative pointer
        step(9'b000_000_001, 9'b000_011_000, '1, "R8 masked");
        step('0, 9'b000_011_000, '0, "R8 follow-up");
        // R3: non-speculative only, every pattern
        for (int n = 0; n < 512; n++) step(NP'(n), '0, '1, "R3 sweep");
        // R6 R7: speculative only, every pattern, varying VC results
        for (int n = 0; n < 512; n++) step('0, NP'(n), NI'(n % 8), "R6 sweep");
        // R4 R5: both classes mixed
        for (int n = 0; n < 512; n++)
            step(NP'((n * 37 + 5) % 512) & NP'(n), NP'((n * 91 + 13) % 512), NI'(n / 3), "R4 R5 mixed");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule